// File: doc/BRIEF.md
# SWD Host Transaction Engine

This block is the host side of a two-wire serial debug link. It turns one register access request (access-port or debug-port select, direction, two address bits, write data) into a complete framed transfer on a clock line and a bidirectional data line with an output enable. It generates the serial clock itself at half the system clock rate. It returns the read word, the final acknowledge code and a sticky error status.

A WAIT acknowledge is handled inside the block. It first writes the debug-port abort register with the four sticky-flag clear bits and then sends the original transfer again. Any other failure is latched. Once an error is latched, every later request completes at once without touching the wire, until a flush request is issued. The flush clocks trailing idle cycles, reports the latched status and clears it. After a successful access-port transfer the engine adds a programmable number of idle clocks with the data line released.

Top module: `swd_host_engine`

## Requirements
- R1: A request byte goes out least significant bit first with the line driven. Bit 0 is the start bit (1), bit 1 is the port select, bit 2 is read (1) or write (0), bits 4:3 are the address, bit 5 is the XOR of bits 4:1, bit 6 is 0 and bit 7 is 1.
- R2: After the request byte the host releases the line for one turnaround bit. It then samples a 3-bit acknowledge, least significant bit first, with the line still released. The codes are OK = 001, WAIT = 010 and FAULT = 100.
- R3: A read with acknowledge OK samples 32 data bits (LSB first) and a parity bit, then has one turnaround bit. It then pulses `done`, shows the word on `rdata` and shows 001 on `ack_code`. A read debug-port transfer takes 46 serial clocks in total.
- R4: A write has one turnaround bit after the acknowledge. With acknowledge OK it then drives 32 data bits (LSB first) and a parity bit equal to the XOR of the data.
- R5: If the parity bit of a read does not equal the XOR of the 32 data bits, `err_status` becomes 5'b11000 and `rdata` keeps its old value.
- R6: On WAIT the host sends a debug-port write to address 0 with data 32'h0000_001E, then sends the original request byte again. The returned data comes from the repeated transfer.
- R7: On FAULT or an undefined acknowledge, `err_status` becomes {2'b10, code} and the transfer ends after the turnaround bit, without a retry and without a data phase. Such a transfer takes 13 serial clocks.
- R8: While `err_status[4]` is set, a request produces a `done` pulse with no serial clock edge.
- R9: After a successful access-port transfer, exactly `ap_idle_cycles` extra serial clocks follow with the line released. Debug-port transfers add none.
- R10: A flush clocks 8 serial clocks with the line released. It then pulses `flush_done`, presents the latched status on `flush_status` and clears `err_status` to 0.
- R11: `swclk` is low while the engine is not busy. The host changes its driven data only while `swclk` is low, and samples the line at the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a transfer (taken when not busy) |
| req_ap | input | 1 | 1 selects access port, 0 debug port |
| req_rnw | input | 1 | 1 read, 0 write |
| req_addr | input | 2 | Register address bits |
| req_wdata | input | 32 | Write data |
| ap_idle_cycles | input | 8 | Idle clocks after a successful access-port transfer |
| flush_req | input | 1 | Flush; wins over a request in the same cycle |
| busy | output | 1 | Engine is running a sequence |
| done | output | 1 | One-cycle pulse at the end of a request |
| rdata | output | 32 | Last good read word |
| ack_code | output | 3 | Final acknowledge of the last transfer |
| err_status | output | 5 | Sticky status: bit 4 error, bit 3 parity, bits 2:0 code |
| flush_done | output | 1 | One-cycle pulse at the end of a flush |
| flush_status | output | 5 | Status reported by the last flush |
| swclk | output | 1 | Serial clock |
| swdio_o | output | 1 | Data driven by the host |
| swdio_oe | output | 1 | Host drives the data line when 1 |
| swdio_i | input | 1 | Data line as seen by the host |

## Verification
A behavioural target answers each frame from a per-frame script of acknowledge codes, data words and parity corruption, and logs every request byte and written word it receives. Debug-port and access-port reads and writes are run with different addresses and idle counts, so the 46-clock frame can be told apart from the frame plus its trailing idle clocks. A WAIT-then-OK script separates a correct abort-and-repeat from a plain retry or a missing abort. FAULT, undefined-code and bad-parity scripts each leave a distinct status word. The requests issued while that status is set, and the flush that follows, show the block ignoring requests and then clearing the error.

// File: rtl/swd_host_pkg.sv
package swd_host_pkg;

  localparam int STAT_W = 5;
  localparam logic [2:0] ACK_OK    = 3'b001;
  localparam logic [2:0] ACK_WAIT  = 3'b010;
  localparam logic [2:0] ACK_FAULT = 3'b100;

  typedef enum logic [3:0] {
    ST_IDLE, ST_REQ, ST_TRN_A, ST_ACK, ST_RDATA,
    ST_TRN_B, ST_WDATA, ST_POST, ST_FLUSH
  } swd_state_e;

  // Request byte, bit 0 leaves the host first.
  function automatic logic [7:0] build_req(input logic ap, input logic rnw,
                                           input logic [1:0] addr);
    logic par;
    par = ap ^ rnw ^ addr[0] ^ addr[1];
    return {1'b1, 1'b0, par, addr[1], addr[0], rnw, ap, 1'b1};
  endfunction

  // Status word: parity failures and acknowledge failures are kept apart.
  function automatic logic [STAT_W-1:0] mk_status(input logic parity_case,
                                                  input logic [2:0] code);
    return parity_case ? 5'b11000 : {2'b10, code};
  endfunction

endpackage

// File: rtl/swd_clk_gen.sv
module swd_clk_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic ph,
  output logic tick_lo,
  output logic tick_hi
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= 1'b0;
    else        ph <= run ? ~ph : 1'b0;
  end

  // tick_lo: last cycle of the low phase (sample point)
  // tick_hi: last cycle of the high phase (bit boundary)
  assign tick_lo = run & ~ph;
  assign tick_hi = run &  ph;
endmodule

// File: rtl/swd_rx_shift.sv
module swd_rx_shift #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         din,
  output logic [W-1:0] q
);
  generate
    if (W == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= {din, q[W-1:1]};
      end
    end
  endgenerate
endmodule

// File: rtl/swd_host_engine.sv
module swd_host_engine
  import swd_host_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int IDLE_W  = 8,
  parameter int FLUSH_N = 8,
  parameter logic [DATA_W-1:0] ABORT_CLR = 'h1E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_ap,
  input  logic              req_rnw,
  input  logic [1:0]        req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [IDLE_W-1:0] ap_idle_cycles,
  input  logic              flush_req,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [2:0]        ack_code,
  output logic [STAT_W-1:0] err_status,
  output logic              flush_done,
  output logic [STAT_W-1:0] flush_status,
  output logic              swclk,
  output logic              swdio_o,
  output logic              swdio_oe,
  input  logic              swdio_i
);
  localparam int DCNT_W = $clog2(DATA_W + 1);
  localparam int FCNT_W = $clog2(FLUSH_N + 1);
  localparam int M1_W   = (DCNT_W > FCNT_W) ? DCNT_W : FCNT_W;
  localparam int CNT_W  = ((M1_W > IDLE_W) ? M1_W : IDLE_W) + 1;
  localparam logic [CNT_W-1:0] LAST_DATA  = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] LAST_FLUSH = CNT_W'(FLUSH_N - 1);

  swd_state_e          state;
  logic [CNT_W-1:0]    bcnt;
  logic                cur_ap, cur_rnw, in_abort;
  logic [1:0]          cur_addr;
  logic [DATA_W-1:0]   cur_wdata;
  logic [IDLE_W-1:0]   idle_n;
  logic [DATA_W:0]     tx_sr;
  logic [STAT_W-1:0]   err_st;
  logic                ph, tick_lo, tick_hi;

  // Fields of the frame on the wire: the abort write replaces the request.
  wire              e_ap    = cur_ap  & ~in_abort;
  wire              e_rnw   = cur_rnw & ~in_abort;
  wire [1:0]        e_addr  = in_abort ? 2'b00 : cur_addr;
  wire [DATA_W-1:0] e_wdata = in_abort ? ABORT_CLR : cur_wdata;
  wire [7:0]        req_bits = build_req(e_ap, e_rnw, e_addr);

  // Named events
  wire run        = (state != ST_IDLE);
  wire in_idle    = (state == ST_IDLE);
  wire flush_go   = in_idle & flush_req;
  wire req_skip   = in_idle & req_valid & ~flush_req &  err_st[STAT_W-1];
  wire req_accept = in_idle & req_valid & ~flush_req & ~err_st[STAT_W-1];
  wire ack_en     = tick_lo & (state == ST_ACK);
  wire rd_en      = tick_lo & (state == ST_RDATA);

  logic [2:0]      ack_val;
  logic [DATA_W:0] rx_q;

  swd_clk_gen u_clk (.clk(clk), .rst_n(rst_n), .run(run),
                     .ph(ph), .tick_lo(tick_lo), .tick_hi(tick_hi));

  swd_rx_shift #(.W(3)) u_ack (.clk(clk), .rst_n(rst_n), .en(ack_en),
                               .din(swdio_i), .q(ack_val));

  swd_rx_shift #(.W(DATA_W + 1)) u_rdat (.clk(clk), .rst_n(rst_n), .en(rd_en),
                                         .din(swdio_i), .q(rx_q));

  wire [DATA_W-1:0] rd_word  = rx_q[DATA_W-1:0];
  wire              par_bad  = rx_q[DATA_W] != (^rd_word);
  wire              ack_ok   = (ack_val == ACK_OK);
  wire              ack_wait = (ack_val == ACK_WAIT);
  wire              wr_go    = ~e_rnw & ack_ok;
  wire              resolve  = tick_hi & (((state == ST_TRN_B) & ~wr_go) |
                                          ((state == ST_WDATA) & (bcnt == LAST_DATA)));
  wire              retry_c  = ack_wait | (ack_ok & in_abort);
  wire              fail_c   = ~retry_c & (~ack_ok | (e_rnw & par_bad));
  wire              retry_evt = resolve & retry_c;
  wire              fail_evt  = resolve & fail_c;
  wire              xfer_begin = req_accept | retry_evt;
  wire              post_go  = cur_ap & (idle_n != '0);
  wire [CNT_W-1:0]  idle_last = CNT_W'(idle_n) - CNT_W'(1);

  always_comb begin
    swdio_oe = 1'b0;
    swdio_o  = 1'b0;
    case (state)
      ST_IDLE:  swdio_oe = 1'b1;
      ST_REQ:   begin swdio_oe = 1'b1; swdio_o = req_bits[bcnt[2:0]]; end
      ST_WDATA: begin swdio_oe = 1'b1; swdio_o = tx_sr[0]; end
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;  bcnt <= '0;
      cur_ap <= 1'b0; cur_rnw <= 1'b0; cur_addr <= '0; cur_wdata <= '0;
      in_abort <= 1'b0; idle_n <= '0; tx_sr <= '0; err_st <= '0;
      done <= 1'b0; flush_done <= 1'b0; flush_status <= '0;
      rdata <= '0; ack_code <= '0;
    end else begin
      done       <= 1'b0;
      flush_done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (flush_go) begin
            state <= ST_FLUSH; bcnt <= '0;
          end else if (req_skip) begin
            done <= 1'b1;
          end else if (req_accept) begin
            cur_ap <= req_ap; cur_rnw <= req_rnw; cur_addr <= req_addr;
            cur_wdata <= req_wdata; idle_n <= ap_idle_cycles;
            in_abort <= 1'b0; state <= ST_REQ; bcnt <= '0;
          end
        end
        ST_REQ: if (tick_hi) begin
          if (bcnt == CNT_W'(7)) begin state <= ST_TRN_A; bcnt <= '0; end
          else bcnt <= bcnt + 1'b1;
        end
        ST_TRN_A: if (tick_hi) state <= ST_ACK;
        ST_ACK: if (tick_hi) begin
          if (bcnt == CNT_W'(2)) begin
            state <= (e_rnw & ack_ok) ? ST_RDATA : ST_TRN_B;
            bcnt  <= '0;
          end else bcnt <= bcnt + 1'b1;
        end
        ST_RDATA: if (tick_hi) begin
          if (bcnt == LAST_DATA) begin state <= ST_TRN_B; bcnt <= '0; end
          else bcnt <= bcnt + 1'b1;
        end
        ST_TRN_B: if (tick_hi & wr_go) begin
          state <= ST_WDATA; bcnt <= '0;
          tx_sr <= {^e_wdata, e_wdata};
        end
        ST_WDATA: if (tick_hi) begin
          tx_sr <= tx_sr >> 1;
          bcnt  <= bcnt + 1'b1;
        end
        ST_POST: if (tick_hi) begin
          if (bcnt == idle_last) begin state <= ST_IDLE; done <= 1'b1; end
          else bcnt <= bcnt + 1'b1;
        end
        ST_FLUSH: if (tick_hi) begin
          if (bcnt == LAST_FLUSH) begin
            state <= ST_IDLE; flush_done <= 1'b1;
            flush_status <= err_st; err_st <= '0;
          end else bcnt <= bcnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase

      // End of a frame: retry, fail or complete (overrides the case above).
      if (resolve) begin
        bcnt <= '0;
        if (retry_c) begin
          state    <= ST_REQ;
          in_abort <= ack_wait;
        end else if (fail_c) begin
          err_st   <= mk_status(ack_ok, ack_val);
          ack_code <= ack_val;
          state    <= ST_IDLE;
          done     <= 1'b1;
        end else begin
          ack_code <= ack_val;
          if (e_rnw) rdata <= rd_word;
          if (post_go) state <= ST_POST;
          else begin state <= ST_IDLE; done <= 1'b1; end
        end
      end
    end
  end

  assign busy       = run;
  assign swclk      = ph;
  assign err_status = err_st;

endmodule

// File: rtl/swd_host_checker.sv
module swd_host_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       swclk,
  input logic       swdio_o,
  input logic       swdio_oe,
  input logic       flush_done,
  input logic [4:0] err_status,
  input logic       ack_sample,
  input logic       xfer_begin,
  input logic       skip_evt,
  input logic       fail_evt
);
  // R11: serial clock parked low when not busy
  p_idle_clk_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !swclk);

  // R11: driven data changes only in the low phase
  p_drive_low_phase_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (swdio_oe && $past(swdio_oe) && (swdio_o != $past(swdio_o))) |-> !swclk);

  // R2: acknowledge sampled with the line released
  p_ack_released_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ack_sample |-> !swdio_oe);

  // R1: every frame opens with a driven start bit of 1
  p_start_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_begin |=> (swdio_oe && swdio_o));

  // R8: a skipped request never starts the clock
  p_skip_no_clock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    skip_evt |=> (!busy && !swclk));

  // R7: a failing frame leaves the error flag set
  p_fail_latched_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fail_evt |=> err_status[4]);

  // R10: the flush clears the status
  p_flush_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |-> (err_status == 5'b00000));
endmodule

bind swd_host_engine swd_host_checker u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .swclk(swclk),
  .swdio_o(swdio_o), .swdio_oe(swdio_oe), .flush_done(flush_done),
  .err_status(err_status), .ack_sample(ack_en), .xfer_begin(xfer_begin),
  .skip_evt(req_skip), .fail_evt(fail_evt)
);

// File: tb/tb_swd_host_engine.sv
`timescale 1ns/1ps
module tb_swd_host_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ap = 1'b0, req_rnw = 1'b0, flush_req = 1'b0;
  logic [1:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [7:0]  ap_idle_cycles = '0;
  logic        busy, done, flush_done, swclk, swdio_o, swdio_oe;
  logic        swdio_i = 1'b0;
  logic [31:0] rdata;
  logic [2:0]  ack_code;
  logic [4:0]  err_status, flush_status;

  always #4 clk = ~clk;

  swd_host_engine dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ap(req_ap),
    .req_rnw(req_rnw), .req_addr(req_addr), .req_wdata(req_wdata),
    .ap_idle_cycles(ap_idle_cycles), .flush_req(flush_req), .busy(busy),
    .done(done), .rdata(rdata), .ack_code(ack_code), .err_status(err_status),
    .flush_done(flush_done), .flush_status(flush_status), .swclk(swclk),
    .swdio_o(swdio_o), .swdio_oe(swdio_oe), .swdio_i(swdio_i)
  );

  int checks = 0, fails = 0, edges = 0, cyc = 0;
  int r2_viol = 0, r11_viol = 0;
  bit finished = 0;

  // ---------------- behavioural target ----------------
  logic [2:0]  ack_plan [16];
  logic [7:0]  req_log  [16];
  logic [31:0] wd_log   [16];
  logic        wpar_log [16];
  logic [31:0] tgt_data = '0;
  logic        corrupt = 1'b0;
  int          frame_no = 0, k = 0;
  bit          in_frame = 0;
  logic [7:0]  cur_req;
  logic [2:0]  cur_ack;
  logic [31:0] cur_wd;

  always @(posedge swclk) begin
    edges++;
    if (!in_frame) begin
      if (swdio_oe && swdio_o) begin
        in_frame = 1; k = 1; cur_req = 8'h01; cur_wd = '0;
        cur_ack = ack_plan[frame_no];
      end
    end else begin
      if (k < 8) cur_req[k] = swdio_o;
      if (k == 7) req_log[frame_no] = cur_req;
      if (k >= 8 && k <= 11 && swdio_oe) r2_viol++;
      if (k >= 13 && k <= 44) cur_wd[k-13] = swdio_o;
      if (k == 45 && !cur_req[2]) wpar_log[frame_no] = swdio_o;
      k++;
      if ((k == 13 && cur_ack != 3'b001) || k == 46) begin
        if (!cur_req[2]) wd_log[frame_no] = cur_wd;
        in_frame = 0;
        frame_no++;
      end
    end
  end

  always @(negedge swclk) begin
    if (in_frame && k >= 9 && k <= 11)
      swdio_i = cur_ack[k-9];
    else if (in_frame && cur_req[2] && cur_ack == 3'b001 && k >= 12 && k <= 43)
      swdio_i = tgt_data[k-12];
    else if (in_frame && cur_req[2] && cur_ack == 3'b001 && k == 44)
      swdio_i = (^tgt_data) ^ corrupt;
    else
      swdio_i = 1'b0;
  end

  // R11 monitor: driven data stable in the high phase, clock low when idle
  logic prev_o = 1'b0, prev_oe = 1'b0;
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (swclk && swdio_oe && prev_oe && (swdio_o != prev_o)) r11_viol++;
      if (!busy && swclk) r11_viol++;
    end
    prev_o = swdio_o; prev_oe = swdio_oe;
  end

  // ---------------- helpers ----------------
  task automatic check_eq(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_req(bit ap, bit rnw, logic [1:0] a);
    int ones = int'(ap) + int'(rnw) + int'(a[0]) + int'(a[1]);
    return 8'h81 + (ap ? 8'd2 : 8'd0) + (rnw ? 8'd4 : 8'd0)
           + 8'(a) * 8'd8 + ((ones % 2) == 1 ? 8'd32 : 8'd0);
  endfunction

  function automatic logic odd_ones(logic [31:0] w);
    int n = 0;
    for (int i = 0; i < 32; i++) n += int'(w[i]);
    return (n % 2) == 1;
  endfunction

  task automatic do_req(bit ap, bit rnw, logic [1:0] a, logic [31:0] wd,
                        logic [7:0] idl, output bit seen);
    seen = 0;
    @(negedge clk);
    req_ap = ap; req_rnw = rnw; req_addr = a; req_wdata = wd;
    ap_idle_cycles = idl; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (done) seen = 1;
    for (int i = 0; i < 5000 && !seen; i++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
  endtask

  task automatic do_flush(output bit seen);
    seen = 0;
    @(negedge clk); flush_req = 1'b1;
    @(negedge clk); flush_req = 1'b0;
    for (int i = 0; i < 2000 && !seen; i++) begin
      if (flush_done) seen = 1;
      else @(negedge clk);
    end
  endtask

  // ---------------- scenarios ----------------
  logic [31:0] last_good;

  task automatic t_reset();
    check_eq("R11 swclk low after reset", swclk, 0);
    check_eq("R11 not busy after reset", busy, 0);
    check_eq("R10 status clear after reset", err_status, 0);
  endtask

  task automatic t_dp_read();
    bit s; int e0;
    frame_no = 0; ack_plan[0] = 3'b001; tgt_data = 32'hA5C3_0F1E;
    e0 = edges;
    do_req(0, 1, 2'b01, 32'h0, 8'd4, s);
    check_eq("R3 done on DP read", s, 1);
    check_eq("R1 request byte DP read a=1", req_log[0], exp_req(0, 1, 2'b01));
    check_eq("R3 read data", rdata, 32'hA5C3_0F1E);
    check_eq("R3 ack OK", ack_code, 3'b001);
    check_eq("R9 DP read has no idle (46 clocks)", edges - e0, 46);
    last_good = rdata;
  endtask

  task automatic t_ap_write();
    bit s; int e0;
    frame_no = 0; ack_plan[0] = 3'b001;
    e0 = edges;
    do_req(1, 0, 2'b10, 32'h1234_5678, 8'd5, s);
    check_eq("R4 done on AP write", s, 1);
    check_eq("R1 request byte AP write a=2", req_log[0], exp_req(1, 0, 2'b10));
    check_eq("R4 write data on wire", wd_log[0], 32'h1234_5678);
    check_eq("R4 write parity", wpar_log[0], odd_ones(32'h1234_5678));
    check_eq("R9 AP write plus 5 idle", edges - e0, 51);
  endtask

  task automatic t_ap_read_idle();
    bit s; int e0;
    frame_no = 0; ack_plan[0] = 3'b001; tgt_data = 32'hFFFF_0001;
    e0 = edges;
    do_req(1, 1, 2'b11, 32'h0, 8'd3, s);
    check_eq("R1 request byte AP read a=3", req_log[0], exp_req(1, 1, 2'b11));
    check_eq("R3 AP read data", rdata, 32'hFFFF_0001);
    check_eq("R9 AP read plus 3 idle", edges - e0, 49);
    last_good = rdata;
  endtask

  task automatic t_wait_retry();
    bit s; int e0;
    frame_no = 0; tgt_data = 32'h0BAD_CAFE;
    ack_plan[0] = 3'b010; ack_plan[1] = 3'b001; ack_plan[2] = 3'b001;
    e0 = edges;
    do_req(0, 1, 2'b10, 32'h0, 8'd0, s);
    check_eq("R6 three frames", frame_no, 3);
    check_eq("R6 abort request byte", req_log[1], exp_req(0, 0, 2'b00));
    check_eq("R6 abort clear bits", wd_log[1], 32'h0000_001E);
    check_eq("R6 original request repeated", req_log[2], exp_req(0, 1, 2'b10));
    check_eq("R6 retried read data", rdata, 32'h0BAD_CAFE);
    check_eq("R6 total clocks 13+46+46", edges - e0, 105);
    check_eq("R6 status clear after retry", err_status, 0);
    last_good = rdata;
  endtask

  task automatic t_fault();
    bit s; int e0;
    frame_no = 0; ack_plan[0] = 3'b100; ack_plan[1] = 3'b001;
    e0 = edges;
    do_req(1, 0, 2'b01, 32'h5555_AAAA, 8'd4, s);
    check_eq("R7 done on FAULT", s, 1);
    check_eq("R7 FAULT status", err_status, 5'b10100);
    check_eq("R7 ack code FAULT", ack_code, 3'b100);
    check_eq("R7 no retry", frame_no, 1);
    check_eq("R7 short frame 13 clocks", edges - e0, 13);
  endtask

  task automatic t_skip();
    bit s; int e0;
    frame_no = 0; ack_plan[0] = 3'b001;
    e0 = edges;
    do_req(0, 1, 2'b00, 32'h0, 8'd0, s);
    check_eq("R8 skipped request done", s, 1);
    check_eq("R8 no clock edges", edges - e0, 0);
    check_eq("R8 status kept", err_status, 5'b10100);
  endtask

  task automatic t_flush(logic [4:0] exp_st);
    bit s; int e0;
    e0 = edges;
    do_flush(s);
    check_eq("R10 flush done", s, 1);
    check_eq("R10 flush status", flush_status, exp_st);
    check_eq("R10 flush 8 clocks", edges - e0, 8);
    @(negedge clk);
    check_eq("R10 status cleared", err_status, 0);
  endtask

  task automatic t_junk();
    bit s;
    frame_no = 0; ack_plan[0] = 3'b111;
    do_req(0, 1, 2'b11, 32'h0, 8'd0, s);
    check_eq("R7 undefined code latched", err_status, 5'b10111);
    check_eq("R7 undefined code no retry", frame_no, 1);
  endtask

  task automatic t_parity();
    bit s;
    frame_no = 0; ack_plan[0] = 3'b001; tgt_data = 32'h1357_9BDF; corrupt = 1'b1;
    do_req(0, 1, 2'b01, 32'h0, 8'd0, s);
    corrupt = 1'b0;
    check_eq("R5 parity error status", err_status, 5'b11000);
    check_eq("R5 read data not returned", rdata, last_good);
  endtask

  // ---------------- main ----------------
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_dp_read();
    t_ap_write();
    t_ap_read_idle();
    t_wait_retry();
    t_fault();
    t_skip();
    t_flush(5'b10100);
    t_junk();
    t_flush(5'b10111);
    t_parity();
    t_flush(5'b11000);
    check_eq("R2 line released around ack", r2_viol, 0);
    check_eq("R11 drive timing and idle clock", r11_viol, 0);
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    wait (cyc >= 150000);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule